// File: doc/BRIEF.md
# Daisy-Chained Interrupt Source Identifier

This block works out which of several devices has an interrupt waiting. It does this with a select token that ripples through a chain of slots. Each slot holds a request flip-flop and has a mask input. A device sets its own flip-flop with a one-cycle pulse. The unmasked requests are ORed together onto one request line to the processor, and that line is gated by a global enable.

When the processor raises its acknowledge, the token enters slot 0 and moves upward through the slots. The first slot that is requesting and unmasked takes the token. It blocks every slot above it and puts its code (the slot index) on the shared code bus, with a valid flag. If no slot takes the token, it leaves the top of the chain. A chain-end output of 1 then reports that no source is pending. The slot that was identified has its request cleared at the clock edge that closes the acknowledge cycle. Bringing a slot's mask high clears that slot's request directly.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset no request is pending. `irq_o`, `valid_o` and `code_o` are 0, and `chain_end_o` follows `ack_i`.
- R2: A pulse on `set_i[k]` with `mask_i[k]` low makes slot k pending from the next clock edge. `irq_o` is 1 while at least one unmasked slot is pending and `gie_i` is 1.
- R3: While `gie_i` is 0, `irq_o` is 0 and pending requests are kept. When `gie_i` returns to 1, `irq_o` is 1 again if a request is still pending.
- R4: In a cycle with `ack_i` high, the pending unmasked slot with the lowest index takes the token. In that same cycle `valid_o` is 1 and `code_o` equals that slot's index. Slot 0 has the highest priority.
- R5: In a cycle with `ack_i` high and no unmasked slot pending, `chain_end_o` is 1, `valid_o` is 0 and `code_o` is 0.
- R6: In a cycle with `ack_i` low, `valid_o`, `code_o` and `chain_end_o` are all 0.
- R7: The slot that took the token has its request cleared at the clock edge that ends the acknowledge cycle. Every other slot keeps its request.
- R8: While `mask_i[k]` is 1, slot k is left out of `irq_o` and out of the chain in that same cycle, and its request is cleared at the next edge. After the mask is released, the slot stays clear until it is set again.
- R9: If `set_i[k]` is pulsed in the same cycle in which slot k is acknowledged, slot k stays pending after the edge.
- R10: If `set_i[k]` and `mask_i[k]` are both 1 in a cycle, slot k is not pending after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | NUM_SRC | Per-device request set pulses |
| mask_i | input | NUM_SRC | Per-device mask; 1 clears and excludes the slot |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Processor acknowledge; injects the select token at slot 0 |
| irq_o | output | 1 | Combined request line to the processor |
| valid_o | output | 1 | A slot has taken the token this cycle |
| code_o | output | CODE_W | Code of the slot that took the token; 0 when none |
| chain_end_o | output | 1 | Token left the top of the chain (no source) |

## Verification
`valid_o`, `code_o`, `chain_end_o` and the masking effect on `irq_o` depend only on the current inputs and the stored requests. They are due in the same cycle as the stimulus. A set pulse, a clear after acknowledge, or a clear by mask is seen one edge later. The driver applies inputs on the falling edge and pushes the expected outputs for that cycle into a queue. The monitor pops each item shortly before the next rising edge and compares it, so every result is read after all inputs have settled and before the edge that changes any state. The bench's own model of which slots are pending is updated only at that rising edge.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
  function automatic int unsigned code_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irq_slot.sv
module irq_slot #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              mask_i,
  input  logic              tok_i,
  output logic              tok_o,
  output logic              take_o,
  output logic              live_o,
  output logic              raw_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MyCode = CODE_W'(IDX);

  logic req_q;

  // mask acts as direct clear; a new set wins over the acknowledge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (mask_i)  req_q <= 1'b0;
    else if (set_i)   req_q <= 1'b1;
    else if (take_o)  req_q <= 1'b0;
  end

  assign live_o = req_q & ~mask_i;
  assign take_o = tok_i & live_o;
  assign tok_o  = tok_i & ~live_o;
  assign raw_o  = req_q;
  assign code_o = take_o ? MyCode : '0;
endmodule

// File: rtl/irq_code_bus.sv
module irq_code_bus #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned CODE_W  = 3
) (
  input  logic [NUM_SRC-1:0][CODE_W-1:0] slot_code_i,
  input  logic [NUM_SRC-1:0]             take_i,
  output logic [CODE_W-1:0]              code_o,
  output logic                           valid_o
);
  // at most one slot takes the token, so an OR merge is exact
  always_comb begin
    code_o = '0;
    for (int i = 0; i < int'(NUM_SRC); i++) code_o |= slot_code_i[i];
  end

  assign valid_o = |take_i;
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned CODE_W  = irq_daisy_pkg::code_width(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               gie_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic               valid_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               chain_end_o
);
  logic [NUM_SRC:0]                tok;
  logic [NUM_SRC-1:0]              take;
  logic [NUM_SRC-1:0]              live;
  logic [NUM_SRC-1:0]              req_q;
  logic [NUM_SRC-1:0][CODE_W-1:0]  slot_code;

  assign tok[0] = ack_i;

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_slot
    irq_slot #(.CODE_W(CODE_W), .IDX(g)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i[g]),
      .mask_i (mask_i[g]),
      .tok_i  (tok[g]),
      .tok_o  (tok[g+1]),
      .take_o (take[g]),
      .live_o (live[g]),
      .raw_o  (req_q[g]),
      .code_o (slot_code[g])
    );
  end

  irq_code_bus #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_bus (
    .slot_code_i (slot_code),
    .take_i      (take),
    .code_o      (code_o),
    .valid_o     (valid_o)
  );

  assign irq_o       = gie_i & (|live);
  assign chain_end_o = tok[NUM_SRC];
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned CODE_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] set_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic               gie_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic               valid_o,
  input logic [CODE_W-1:0]  code_o,
  input logic               chain_end_o,
  input logic [NUM_SRC-1:0] req_q
);
  a_r3_gie_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> (!valid_o && code_o == '0 && !chain_end_o));

  a_r5_end_xor_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> (valid_o != chain_end_o));

  a_r4_claim_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req_q[code_o] && !mask_i[code_o]));

  a_r7_claim_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && valid_o) |=> (!req_q[$past(code_o)] || $past(set_i[code_o])));

  a_r8_mask_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i != '0) |=> ((req_q & $past(mask_i)) == '0));
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_i       (set_i),
  .mask_i      (mask_i),
  .gie_i       (gie_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .valid_o     (valid_o),
  .code_o      (code_o),
  .chain_end_o (chain_end_o),
  .req_q       (req_q)
);

// File: tb/irq_daisy_chain_test.sv
module irq_daisy_chain_test;
  localparam int N  = 8;
  localparam int CW = 3;

  typedef struct {
    string          tag;
    logic           irq;
    logic           valid;
    logic [CW-1:0]  code;
    logic           chain_end;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  set = '0;
  logic [N-1:0]  mask = '0;
  logic          gie = 1'b0;
  logic          ack = 1'b0;
  logic          irq, valid, chain_end;
  logic [CW-1:0] code;

  logic [N-1:0]  model = '0;
  exp_t          sb[$];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  irq_daisy_chain #(.NUM_SRC(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set), .mask_i(mask), .gie_i(gie),
    .ack_i(ack), .irq_o(irq), .valid_o(valid), .code_o(code), .chain_end_o(chain_end)
  );

  // driver: apply one cycle of stimulus, push expectation, advance model at edge
  task automatic step(input logic [N-1:0] s, input logic [N-1:0] m,
                      input logic g, input logic a, input string tag);
    exp_t e;
    logic [N-1:0] live;
    int win;
    set = s; mask = m; gie = g; ack = a;
    live = model & ~m;
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (live[i]) win = i;
    e.tag = tag;
    e.irq = g & (|live);
    e.valid = a && win >= 0;
    e.code = e.valid ? CW'(win) : '0;
    e.chain_end = a && win < 0;
    sb.push_back(e);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (m[i])                    model[i] = 1'b0;
      else if (s[i])               model[i] = 1'b1;
      else if (e.valid && win == i) model[i] = 1'b0;
    end
    @(negedge clk);
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (irq !== e.irq || valid !== e.valid || code !== e.code ||
            chain_end !== e.chain_end) begin
          n_fail++;
          $display("FAIL %s: irq/valid/code/end = %b/%b/%0d/%b expected %b/%b/%0d/%b",
                   e.tag, irq, valid, code, chain_end, e.irq, e.valid, e.code, e.chain_end);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    step('0, '0, 1, 0, "R1");
    step('0, '0, 1, 1, "R1");
    // R2 set latches, irq next cycle
    step(8'h20, '0, 1, 0, "R2");
    step('0, '0, 1, 0, "R2");
    // R3 global enable gates without losing request
    step('0, '0, 0, 0, "R3");
    step('0, '0, 0, 0, "R3");
    step('0, '0, 1, 0, "R3");
    // R4 priority, R7 clear, R5 empty chain
    step(8'h04, '0, 1, 0, "R4");
    step('0, '0, 1, 1, "R4");
    step('0, '0, 1, 1, "R7");
    step('0, '0, 1, 1, "R5");
    step('0, '0, 1, 0, "R6");
    // R8 mask clears and excludes
    step(8'h08, '0, 1, 0, "R8");
    step('0, 8'h08, 1, 1, "R8");
    step('0, '0, 1, 1, "R8");
    step(8'h03, '0, 1, 0, "R8");
    step('0, 8'h01, 1, 1, "R8");
    step('0, '0, 1, 1, "R8");
    // R9 set wins over acknowledge clear
    step(8'h02, '0, 1, 0, "R9");
    step(8'h02, '0, 1, 1, "R9");
    step('0, '0, 1, 1, "R9");
    step('0, '0, 1, 1, "R9");
    // R10 mask wins over set
    step(8'h40, 8'h40, 1, 0, "R10");
    step('0, '0, 1, 1, "R10");
    // R4 full sweep: all slots identified in priority order
    step('1, '0, 1, 0, "R4");
    for (int i = 0; i < N; i++) step('0, '0, 1, 1, "R4");
    step('0, '0, 1, 1, "R5");
    // R6 idle with requests pending
    step(8'h81, '0, 1, 0, "R6");
    step('0, '0, 0, 0, "R6");
    step('0, '0, 1, 1, "R7");
    step('0, '0, 1, 1, "R7");
    step('0, '0, 1, 0, "R6");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule